// File: doc/BRIEF.md
# Two-wire bus timing watcher

This block listens to the clock and data lines of a two-wire serial bus without driving them. A system clock much faster than the bus samples both lines. The block then measures every bus interval as a count of system-clock cycles. It finds start, repeated start and stop conditions and times the clock high and low phases, the clock period, the data setup before a clock rise, the setup and hold around the conditions, and the idle gap between a stop and the next start.

A run-time input chooses one of two tables of minimum times: a 400 kHz table or a 100 kHz table. Every limit is derived from the system-clock frequency parameter and rounded up to whole cycles. When an interval falls short of its limit, a sticky flag for that kind of fault is set and a saturating counter goes up. A synchronous clear input resets both the flags and the counter. The block suits bus bring-up and in-system compliance watching.

Top module: `bus_timing_watch`

## Requirements
- R1: After reset, `viol_flags` is 0 and `viol_count` is 0.
- R2: Flag bit 0 is set when the clock high time, from a clock rise to the next clock fall, is below 0.6 us (fast table) or 4.0 us (standard table).
- R3: Flag bit 1 is set when the clock low time, from a clock fall to the next clock rise, is below 1.2 us (fast) or 4.7 us (standard).
- R4: Flag bit 2 is set when the time from a start condition to the first clock fall after it is below 0.6 us (fast) or 4.0 us (standard).
- R5: Flag bit 3 is set when a start condition arrives while the bus is busy (a repeated start) less than 0.6 us (fast) or 4.7 us (standard) after the last clock rise.
- R6: Flag bit 4 is set when, while the bus is busy, a clock rise comes less than 100 ns (fast) or 250 ns (standard) after the last data-line change.
- R7: Flag bit 5 is set when a stop condition comes less than 0.6 us (fast) or 4.7 us (standard) after the last clock rise.
- R8: Flag bit 6 is set when a start condition on an idle bus comes less than 1.2 us (fast) or 4.7 us (standard) after the previous stop.
- R9: Flag bit 7 is set when two clock rises are less than 2.5 us apart (fast) or 10 us apart (standard). A slower clock is legal in either table.
- R10: Each limit is ceil(time x CLK_HZ / 1e9) cycles. An interval of exactly the limit passes, and one cycle less is a fault. `fast_mode`=1 selects the fast table.
- R11: A start is a falling data line and a stop is a rising data line, each while the clock line is high in the current sample and in the one before. A data change in the same sample as a clock edge is neither a start nor a stop.
- R12: Flags are sticky. `viol_count` adds the number of fault kinds raised in a cycle and saturates at 65535.
- R13: `clear` takes effect at the next clock edge. A fault raised at that same edge is kept, so the flags then equal the new faults and the count equals their number.
- R14: Both lines pass through a two-flop synchroniser. A fault caused by an input change shows on the outputs after the third rising clock edge that samples the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| fast_mode | input | 1 | 1 selects the 400 kHz table, 0 the 100 kHz table |
| clear | input | 1 | Synchronous clear of flags and counter |
| viol_flags | output | 8 | Sticky fault flags, one bit per kind (see R2 to R9) |
| viol_count | output | 16 | Saturating count of faults |

## Verification
Two events can fall on the same clock edge: the clear and the recording of a new fault. The bench provokes this by timing a short clock-high phase so that its fault commits on the very edge where `clear` is sampled. It then expects the flags to hold only that fault and the count to be 1, rather than 0 or the old count plus one. A second collision is a data-line change in the same sample as a clock edge. It is driven on purpose, and the bench judges it by the absence of a start-hold fault that a wrongly detected start would cause.

// File: rtl/twt_pkg.sv
package twt_pkg;

  // fault kinds, also the bit positions in the flag vector
  localparam int NKIND           = 8;
  localparam int K_SCL_HI        = 0;
  localparam int K_SCL_LO        = 1;
  localparam int K_START_HOLD    = 2;
  localparam int K_RESTART_SETUP = 3;
  localparam int K_DATA_SETUP    = 4;
  localparam int K_STOP_SETUP    = 5;
  localparam int K_IDLE_GAP      = 6;
  localparam int K_PERIOD        = 7;

  // elapsed-time counters, one per reference event
  localparam int NTIMER = 4;
  localparam int T_RISE = 0;
  localparam int T_FALL = 1;
  localparam int T_SDA  = 2;
  localparam int T_COND = 3;

  // minimum interval in nanoseconds for a kind and table
  function automatic longint unsigned min_ns(input int kind, input logic fast);
    case (kind)
      K_SCL_HI:        return fast ? 64'd600  : 64'd4000;
      K_SCL_LO:        return fast ? 64'd1200 : 64'd4700;
      K_START_HOLD:    return fast ? 64'd600  : 64'd4000;
      K_RESTART_SETUP: return fast ? 64'd600  : 64'd4700;
      K_DATA_SETUP:    return fast ? 64'd100  : 64'd250;
      K_STOP_SETUP:    return fast ? 64'd600  : 64'd4700;
      K_IDLE_GAP:      return fast ? 64'd1200 : 64'd4700;
      default:         return fast ? 64'd2500 : 64'd10000;
    endcase
  endfunction

  // round-up conversion of nanoseconds to system-clock cycles
  function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                               input longint unsigned clk_hz);
    return 32'((ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/twt_sync.sv
module twt_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta;

  // idle bus level is high, so everything resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= '1;
      q      <= '1;
      q_prev <= '1;
    end else begin
      meta   <= d;
      q      <= meta;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/twt_elapsed.sv
module twt_elapsed #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] count
);
  // count = cycles since the last restart; saturated means "long ago"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '1;
    else if (restart)      count <= W'(1);
    else if (count != '1)  count <= count + W'(1);
  end
endmodule

// File: rtl/twt_tally.sv
module twt_tally #(
  parameter int K  = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [K-1:0]  new_viol,
  output logic [K-1:0]  flags,
  output logic [CW-1:0] count
);
  localparam int SW = CW + 1;

  logic [SW-1:0] sum;
  logic [CW-1:0] base;

  always_comb begin
    base = clear ? '0 : count;
    sum  = {1'b0, base} + SW'($countones(new_viol));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      count <= '0;
    end else begin
      flags <= (clear ? '0 : flags) | new_viol;
      count <= sum[CW] ? '1 : sum[CW-1:0];
    end
  end
endmodule

// File: rtl/bus_timing_watch.sv
module bus_timing_watch
  import twt_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 100_000_000,
  parameter int              CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             fast_mode,
  input  logic             clear,
  output logic [NKIND-1:0] viol_flags,
  output logic [CNT_W-1:0] viol_count
);
  localparam int unsigned LIM_MAX = ns_to_cycles(min_ns(K_PERIOD, 1'b0), CLK_HZ);
  localparam int          TW      = $clog2(LIM_MAX + 1) + 1;

  // synchronised lines: bit 1 clock, bit 0 data
  logic [1:0] line_now, line_prev;
  twt_sync #(.W(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      ({scl_in, sda_in}),
    .q      (line_now),
    .q_prev (line_prev)
  );

  // named bus events
  logic scl_rise, scl_fall, sda_edge, scl_steady_hi, start_ev, stop_ev;
  always_comb begin
    scl_rise      = line_now[1] & ~line_prev[1];
    scl_fall      = ~line_now[1] & line_prev[1];
    sda_edge      = line_now[0] ^ line_prev[0];
    scl_steady_hi = line_now[1] & line_prev[1];
    start_ev      = scl_steady_hi & ~line_now[0] & line_prev[0];
    stop_ev       = scl_steady_hi & line_now[0] & ~line_prev[0];
  end

  // per-kind limit, chosen from the two tables
  logic [TW-1:0] lim [NKIND];
  for (genvar k = 0; k < NKIND; k++) begin : g_lim
    localparam int unsigned LF = ns_to_cycles(min_ns(k, 1'b1), CLK_HZ);
    localparam int unsigned LS = ns_to_cycles(min_ns(k, 1'b0), CLK_HZ);
    assign lim[k] = fast_mode ? TW'(LF) : TW'(LS);
  end

  // elapsed-time counters
  logic [NTIMER-1:0] restart;
  logic [TW-1:0]     since [NTIMER];
  always_comb begin
    restart         = '0;
    restart[T_RISE] = scl_rise;
    restart[T_FALL] = scl_fall;
    restart[T_SDA]  = sda_edge;
    restart[T_COND] = start_ev | stop_ev;
  end

  for (genvar t = 0; t < NTIMER; t++) begin : g_timer
    twt_elapsed #(.W(TW)) u_el (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart[t]),
      .count   (since[t])
    );
  end

  // bus state: busy between start and stop, hold pending until first clock fall
  logic busy, hold_pend;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      hold_pend <= 1'b0;
    end else begin
      if (start_ev)     busy <= 1'b1;
      else if (stop_ev) busy <= 1'b0;
      if (start_ev)                  hold_pend <= 1'b1;
      else if (stop_ev || scl_fall)  hold_pend <= 1'b0;
    end
  end

  // fault detection
  logic [NKIND-1:0] new_viol;
  always_comb begin
    new_viol                  = '0;
    new_viol[K_SCL_HI]        = scl_fall & (since[T_RISE] < lim[K_SCL_HI]);
    new_viol[K_SCL_LO]        = scl_rise & (since[T_FALL] < lim[K_SCL_LO]);
    new_viol[K_START_HOLD]    = scl_fall & hold_pend & (since[T_COND] < lim[K_START_HOLD]);
    new_viol[K_RESTART_SETUP] = start_ev & busy & (since[T_RISE] < lim[K_RESTART_SETUP]);
    new_viol[K_DATA_SETUP]    = scl_rise & busy & (since[T_SDA] < lim[K_DATA_SETUP]);
    new_viol[K_STOP_SETUP]    = stop_ev & (since[T_RISE] < lim[K_STOP_SETUP]);
    new_viol[K_IDLE_GAP]      = start_ev & ~busy & (since[T_COND] < lim[K_IDLE_GAP]);
    new_viol[K_PERIOD]        = scl_rise & (since[T_RISE] < lim[K_PERIOD]);
  end

  twt_tally #(.K(NKIND), .CW(CNT_W)) u_tally (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .new_viol (new_viol),
    .flags    (viol_flags),
    .count    (viol_count)
  );
endmodule

// File: rtl/twt_chk.sv
module twt_chk #(
  parameter int K  = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear,
  input logic          start_ev,
  input logic          stop_ev,
  input logic [K-1:0]  new_viol,
  input logic [K-1:0]  viol_flags,
  input logic [CW-1:0] viol_count
);
  // R11
  cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ev && stop_ev));

  // R12
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((viol_flags & $past(viol_flags)) == $past(viol_flags)));

  // R12
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> viol_count >= $past(viol_count));

  // R12
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && new_viol != '0 && viol_count != '1) |=> viol_count != $past(viol_count));

  // R13
  clear_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> viol_flags == $past(new_viol));
endmodule

bind bus_timing_watch twt_chk #(.K(twt_pkg::NKIND), .CW(CNT_W)) u_twt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .start_ev   (start_ev),
  .stop_ev    (stop_ev),
  .new_viol   (new_viol),
  .viol_flags (viol_flags),
  .viol_count (viol_count)
);

// File: tb/test_bus_timing_watch.sv
module test_bus_timing_watch;
  localparam int CLK_MHZ = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_in = 1'b1, sda_in = 1'b1, fast_mode = 1'b1, clear = 1'b0;
  logic [7:0]  viol_flags;
  logic [15:0] viol_count;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_timing_watch i_bus_timing_watch (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .fast_mode(fast_mode), .clear(clear),
    .viol_flags(viol_flags), .viol_count(viol_count)
  );

  // ---------------- behavioural reference ----------------
  function automatic int need(input int kind, input bit f);
    int ns;
    case (kind)
      0: ns = f ? 600  : 4000;
      1: ns = f ? 1200 : 4700;
      2: ns = f ? 600  : 4000;
      3: ns = f ? 600  : 4700;
      4: ns = f ? 100  : 250;
      5: ns = f ? 600  : 4700;
      6: ns = f ? 1200 : 4700;
      default: ns = f ? 2500 : 10000;
    endcase
    return (ns * CLK_MHZ + 999) / 1000;
  endfunction

  logic [1:0] hist[$];
  int  now_c, t_rise, t_fall, t_sda, t_cond;
  bit  m_busy, m_pend;
  logic [7:0] m_flags;
  int  m_count;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {2'b11, 2'b11, 2'b11, 2'b11};
      now_c = 0; t_rise = -100000; t_fall = -100000; t_sda = -100000; t_cond = -100000;
      m_busy = 0; m_pend = 0; m_flags = 0; m_count = 0;
    end else begin
      logic [1:0] c, p;
      logic [7:0] nv;
      bit rise, fall, sedge, st, sp;
      now_c++;
      hist.push_front({scl_in, sda_in});
      void'(hist.pop_back());
      c = hist[2];
      p = hist[3];
      rise  = c[1] && !p[1];
      fall  = !c[1] && p[1];
      sedge = c[0] != p[0];
      st = c[1] && p[1] && !c[0] && p[0];
      sp = c[1] && p[1] && c[0] && !p[0];
      nv = 0;
      if (fall && now_c - t_rise < need(0, fast_mode)) nv[0] = 1;
      if (rise && now_c - t_fall < need(1, fast_mode)) nv[1] = 1;
      if (fall && m_pend && now_c - t_cond < need(2, fast_mode)) nv[2] = 1;
      if (st && m_busy && now_c - t_rise < need(3, fast_mode)) nv[3] = 1;
      if (rise && m_busy && now_c - t_sda < need(4, fast_mode)) nv[4] = 1;
      if (sp && now_c - t_rise < need(5, fast_mode)) nv[5] = 1;
      if (st && !m_busy && now_c - t_cond < need(6, fast_mode)) nv[6] = 1;
      if (rise && now_c - t_rise < need(7, fast_mode)) nv[7] = 1;
      if (st) m_pend = 1; else if (sp || fall) m_pend = 0;
      if (st) m_busy = 1; else if (sp) m_busy = 0;
      if (rise) t_rise = now_c;
      if (fall) t_fall = now_c;
      if (sedge) t_sda = now_c;
      if (st || sp) t_cond = now_c;
      if (clear) begin m_flags = 0; m_count = 0; end
      m_flags |= nv;
      m_count += $countones(nv);
      if (m_count > 65535) m_count = 65535;
    end
  end

  // per-cycle comparison against the reference (R12 covers flags and counter)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (viol_flags !== m_flags || viol_count !== 16'(m_count)) begin
        fails++;
        if (fails < 20)
          $display("FAIL R12 reference flags act %h exp %h count act %0d exp %0d",
                   viol_flags, m_flags, viol_count, m_count);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic put(input logic c, input logic d, input int n);
    scl_in = c;
    sda_in = d;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // start, three bits 1,0,1, stop; bus must be idle high on entry
  task automatic xfer(input int th, input int tl, input int hd, input int sd,
                      input int ss, input int idle);
    logic b, prv;
    b = 1'b1;
    prv = 1'b0;
    put(1, 0, hd);
    for (int i = 0; i < 3; i++) begin
      put(0, prv, tl - sd);
      put(0, b, sd);
      put(1, b, th);
      prv = b;
      b = ~b;
    end
    put(0, 0, tl);
    put(1, 0, ss);
    put(1, 1, idle);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags after reset", viol_flags, 0);
    chk("R1 count after reset", viol_count, 0);
    put(1, 1, 200);

    // fast table, every interval exactly at its limit
    xfer(130, 130, 60, 10, 60, 120);
    xfer(130, 130, 60, 10, 60, 200);
    chk("R10 exact limits pass, idle gap 120 (R8)", viol_flags, 0);

    do_clear();
    xfer(59, 200, 60, 10, 60, 200);
    chk("R2 short high", viol_flags, 8'h01);
    chk("R12 count of three short highs", viol_count, 3);

    do_clear();
    xfer(200, 119, 60, 10, 60, 200);
    chk("R3 short low", viol_flags, 8'h02);
    chk("R12 count of four short lows", viol_count, 4);

    do_clear();
    xfer(130, 130, 59, 10, 60, 200);
    chk("R4 short start hold", viol_flags, 8'h04);

    do_clear();
    xfer(130, 130, 60, 9, 60, 200);
    chk("R6 short data setup", viol_flags, 8'h10);

    do_clear();
    xfer(130, 130, 60, 10, 59, 200);
    chk("R7 short stop setup", viol_flags, 8'h20);

    do_clear();
    xfer(130, 130, 60, 10, 60, 119);
    xfer(130, 130, 60, 10, 60, 200);
    chk("R8 short idle gap", viol_flags, 8'h40);

    do_clear();
    xfer(100, 140, 60, 10, 60, 200);
    chk("R9 short period", viol_flags, 8'h80);

    // repeated start with setup one short, then exact
    for (int su = 59; su <= 60; su++) begin
      do_clear();
      put(1, 0, 60); put(0, 0, 140); put(1, 0, 130);
      put(0, 1, 140); put(1, 1, su); put(1, 0, 60);
      put(0, 0, 140); put(1, 0, 60); put(1, 1, 200);
      chk($sformatf("R5 repeated start setup %0d", su), viol_flags, (su == 59) ? 8'h08 : 8'h00);
    end

    do_clear();
    xfer(1000, 1000, 60, 10, 60, 1000);
    chk("R9 slow clock legal in fast table", viol_flags, 0);

    // standard table
    fast_mode = 1'b0;
    do_clear();
    xfer(130, 130, 60, 10, 60, 1000);
    chk("R10 fast timing judged by standard table", viol_flags, 8'hB7);
    do_clear();
    xfer(400, 600, 400, 25, 470, 470);
    xfer(400, 600, 400, 25, 470, 600);
    chk("R10 standard exact limits pass", viol_flags, 0);
    fast_mode = 1'b1;

    // data change together with clock edges is no condition
    do_clear();
    put(0, 1, 300); put(1, 0, 10); put(0, 0, 300); put(1, 1, 300);
    chk("R11 simultaneous edges are not start/stop", viol_flags, 8'h01);

    // latency through the synchroniser
    do_clear();
    put(0, 1, 300); put(1, 1, 10);
    scl_in = 1'b0;
    @(negedge clk);
    chk("R14 no flag after first edge", viol_flags, 0);
    @(negedge clk);
    chk("R14 no flag after second edge", viol_flags, 0);
    @(negedge clk);
    chk("R14 flag after third edge", viol_flags, 8'h01);
    repeat (300) @(negedge clk);

    // clear and new fault on the same edge
    chk("R13 count before clear", viol_count, 1);
    put(1, 1, 10);
    scl_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    repeat (5) @(negedge clk);
    chk("R13 flags keep same-edge fault", viol_flags, 8'h01);
    chk("R13 count equals same-edge faults", viol_count, 1);

    // saturation
    for (int i = 0; i < 22000; i++) begin
      put(0, 1, 2);
      put(1, 1, 2);
    end
    put(1, 1, 20);
    chk("R12 counter saturates", viol_count, 16'hFFFF);
    chk("R12 flags after fast toggling", viol_flags, 8'h83);

    done = 1;
    summary();
    $finish;
  end
endmodule